// File: doc/BRIEF.md
# Per-Pin Interrupt Detect Controller

This block watches up to 32 already-synchronised input pins and raises a single interrupt when any of them meets the condition chosen for it. Each pin has its own control word. A 4-bit mode field in that word selects one of these behaviours: no detection, a low level, a high level, a rising edge, a falling edge, or either edge. Edge detection compares the pin's present level with its level one cycle earlier.

Every detected event sets that pin's bit in a shared status register. Software clears a bit by writing a one to it. Level modes set their flag again on every cycle while the condition holds, so a level source cannot be cleared until the pin goes inactive. The OR of all flags is registered and drives one interrupt line. Software reaches the control words and the status register through a simple single-cycle register bus. Writes take effect at the clock edge, and reads return data combinationally.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every control word reads 0, the status register reads 0 and `irq_o` is 0.
- R2: Pin n's control word is at byte address 4*n. Its mode field is bits 19:16. A read returns the stored mode in bits 19:16 and zeros in every other bit.
- R3: Mode 0x0, and any code other than 0x8, 0x9, 0xA, 0xB or 0xC, never sets the pin's flag, whatever the pin does.
- R4: Mode 0x8 (low level) sets the flag on every cycle the pin is 0. A clear issued while the pin stays low does not leave the flag at 0.
- R5: Mode 0xC (high level) sets the flag on every cycle the pin is 1.
- R6: Mode 0x9 sets the flag only when the pin was 0 in the previous cycle and is 1 now. A pin held high does not set the flag again after a clear.
- R7: Mode 0xA sets the flag only when the pin goes from 1 to 0.
- R8: Mode 0xB sets the flag on a 0-to-1 change and on a 1-to-0 change.
- R9: The status register is at address 0xA0, and bit n belongs to pin n. Writing a 1 to a bit clears it. Bits written as 0 keep their value, and writing all ones clears every flag.
- R10: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: `irq_o` equals, one cycle later, the OR of all status flags.
- R12: Writing 0 to a pin's control word stops new events for that pin. A flag that is already set stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NPIN | Synchronised pin levels |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Each mode is driven with a single low pulse, a single high pulse and a held level. The pulse tells an edge mode apart from a level mode, and the held level separates a mode that re-arms from one that fires once. The rising and falling modes each get the wrong-direction transition first, which exposes swapped encodings. Either-edge mode gets both transitions with a clear in between. Unlisted codes get the same toggles and must stay silent. Two collision cases are covered: a clear landing in the same cycle as an edge, and a clear issued during a held level. A partial clear with two flags set shows that zero bits in the clear write leave the other flags alone.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // Position of the mode field inside a pin control word.
    localparam int MODE_LSB = 16;
    localparam int MODE_W   = 4;

    typedef enum logic [3:0] {
        MODE_OFF     = 4'h0,
        MODE_LOW     = 4'h8,
        MODE_RISE    = 4'h9,
        MODE_FALL    = 4'hA,
        MODE_ANY     = 4'hB,
        MODE_HIGH    = 4'hC
    } det_mode_e;

    // Detection rule for one pin: current level against the previous cycle's level.
    function automatic logic det_hit(input logic [3:0] mode, input logic cur, input logic prev);
        logic hit;
        case (mode)
            MODE_LOW:  hit = !cur;
            MODE_HIGH: hit = cur;
            MODE_RISE: hit = cur && !prev;
            MODE_FALL: hit = !cur && prev;
            MODE_ANY:  hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pin_mode_regs.sv
module pin_mode_regs #(
    parameter int NPIN  = 32,
    parameter int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [3:0]            wr_mode,
    output logic [NPIN-1:0][3:0]  mode_o
);

    typedef struct packed {
        logic [NPIN-1:0][3:0] mode;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mode[wr_idx] = wr_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
    parameter int NPIN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIN-1:0]       pin_lvl,
    input  logic [NPIN-1:0][3:0]  mode_i,
    output logic [NPIN-1:0]       event_o
);
    import pin_irq_pkg::*;

    typedef struct packed {
        logic [NPIN-1:0] prev;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign event_o[g] = det_hit(mode_i[g], pin_lvl[g], st_q.prev[g]);
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] event_i,
    input  logic [NPIN-1:0] clr_i,
    output logic [NPIN-1:0] flag_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [NPIN-1:0] flag;
        logic            irq;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first, then set: a same-cycle event survives the clear.
        st_d.flag = (st_q.flag & ~clr_i) | event_i;
        st_d.irq  = |st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
    parameter int                NPIN     = 32,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_ADR = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_lvl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    import pin_irq_pkg::*;

    localparam int IDX_W  = (NPIN > 1) ? $clog2(NPIN) : 1;
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]      word_idx;
    logic                   ctrl_hit;
    logic                   stat_hit;
    logic [IDX_W-1:0]       pin_idx;
    logic [NPIN-1:0][3:0]   mode_vec;
    logic [NPIN-1:0]        pin_event;
    logic [NPIN-1:0]        flag_vec;
    logic [NPIN-1:0]        clr_vec;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign pin_idx  = word_idx[IDX_W-1:0];
    assign ctrl_hit = (bus_addr[1:0] == 2'b00) && (int'(word_idx) < NPIN);
    assign stat_hit = (bus_addr == STAT_ADR);
    assign clr_vec  = (bus_wen && stat_hit) ? bus_wdata[NPIN-1:0] : '0;

    pin_mode_regs #(.NPIN(NPIN), .IDX_W(IDX_W)) u_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wen && ctrl_hit),
        .wr_idx  (pin_idx),
        .wr_mode (bus_wdata[MODE_LSB +: MODE_W]),
        .mode_o  (mode_vec)
    );

    pin_edge_detect #(.NPIN(NPIN)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .mode_i  (mode_vec),
        .event_o (pin_event)
    );

    irq_flag_bank #(.NPIN(NPIN)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (pin_event),
        .clr_i   (clr_vec),
        .flag_o  (flag_vec),
        .irq_o   (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata[MODE_LSB +: MODE_W] = mode_vec[pin_idx];
        end else if (stat_hit) begin
            bus_rdata[NPIN-1:0] = flag_vec;
        end
    end

endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
    parameter int                NPIN     = 32,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_ADR = 8'hA0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic [31:0]       bus_wdata,
    input logic [NPIN-1:0]   pin_event,
    input logic [NPIN-1:0]   flag_vec,
    input logic              irq_o
);

    logic            stat_wr;
    logic [NPIN-1:0] wr_ones;

    assign stat_wr = bus_wen && (bus_addr == STAT_ADR);
    assign wr_ones = bus_wdata[NPIN-1:0];

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((flag_vec & $past(wr_ones & ~pin_event)) == '0));

    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flag_vec & ~$past(flag_vec) & ~$past(pin_event)) == '0));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_event) |=> ((flag_vec & $past(pin_event)) == $past(pin_event)));

    p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_vec) |=> irq_o);

    p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|flag_vec) |=> !irq_o);

endmodule

bind pin_irq_detect pin_irq_detect_chk #(
    .NPIN(NPIN), .ADDR_W(ADDR_W), .STAT_ADR(STAT_ADR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .pin_event (pin_event),
    .flag_vec  (flag_vec),
    .irq_o     (irq_o)
);

// File: tb/pin_irq_detect_tb.sv
module pin_irq_detect_tb;

    localparam logic [7:0] STAT = 8'hA0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pin_irq_detect u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input int pin);
        return 8'(pin * 4);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_pin(input int pin, input logic v);
        @(negedge clk);
        pin_lvl[pin] = v;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cleanup();
        for (int i = 0; i < 32; i++) wr(ctl(i), 32'h0);
        pin_lvl = '0;
        tick(2);
        wr(STAT, 32'hFFFF_FFFF);
        tick(2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(ctl(0), v);  check("R1 ctrl0", v, 32'h0);
        rd(ctl(31), v); check("R1 ctrl31", v, 32'h0);
        rd(STAT, v);    check("R1 status", v, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_ctrl_map();
        logic [31:0] v;
        wr(ctl(9), 32'hFFFF_FFFF);
        rd(ctl(9), v);  check("R2 ctrl9 field only", v, 32'h000F_0000);
        wr(ctl(31), 32'h000B_0000);
        rd(ctl(31), v); check("R2 ctrl31 at 0x7C", v, 32'h000B_0000);
        rd(ctl(30), v); check("R2 neighbour untouched", v, 32'h0);
        cleanup();
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(ctl(1), 32'h0000_0000);
        wr(ctl(2), 32'h0005_0000);
        wr(ctl(4), 32'h000F_0000);
        for (int k = 0; k < 2; k++) begin
            set_pin(1, 1'b1); set_pin(2, 1'b1); set_pin(4, 1'b1);
            tick(1);
            set_pin(1, 1'b0); set_pin(2, 1'b0); set_pin(4, 1'b0);
            tick(1);
        end
        rd(STAT, v); check("R3 off/unlisted silent", v, 32'h0);
        check("R3 irq quiet", {31'h0, irq_o}, 32'h0);
        cleanup();
    endtask

    task automatic t_level_low();
        logic [31:0] v;
        pin_lvl[5] = 1'b1;
        wr(ctl(5), 32'h0008_0000);
        tick(2);
        rd(STAT, v); check("R4 high pin no flag", v, 32'h0);
        set_pin(5, 1'b0);
        tick(1);
        rd(STAT, v); check("R4 low sets flag", v, 32'h20);
        wr(STAT, 32'h20);
        rd(STAT, v); check("R4 re-set while low", v, 32'h20);
        set_pin(5, 1'b1);
        wr(STAT, 32'h20);
        rd(STAT, v); check("R4 clears once high", v, 32'h0);
        cleanup();
    endtask

    task automatic t_level_high();
        logic [31:0] v;
        wr(ctl(6), 32'h000C_0000);
        tick(2);
        rd(STAT, v); check("R5 low pin no flag", v, 32'h0);
        set_pin(6, 1'b1);
        tick(1);
        rd(STAT, v); check("R5 high sets flag", v, 32'h40);
        wr(STAT, 32'h40);
        rd(STAT, v); check("R5 re-set while high", v, 32'h40);
        cleanup();
    endtask

    task automatic t_rising();
        logic [31:0] v;
        pin_lvl[3] = 1'b1;
        wr(ctl(3), 32'h0009_0000);
        set_pin(3, 1'b0);
        tick(1);
        rd(STAT, v); check("R6 fall ignored", v, 32'h0);
        set_pin(3, 1'b1);
        tick(1);
        rd(STAT, v); check("R6 rise sets flag", v, 32'h8);
        wr(STAT, 32'h8);
        tick(2);
        rd(STAT, v); check("R6 no re-set when held", v, 32'h0);
        cleanup();
    endtask

    task automatic t_falling();
        logic [31:0] v;
        wr(ctl(7), 32'h000A_0000);
        set_pin(7, 1'b1);
        tick(1);
        rd(STAT, v); check("R7 rise ignored", v, 32'h0);
        set_pin(7, 1'b0);
        tick(1);
        rd(STAT, v); check("R7 fall sets flag", v, 32'h80);
        cleanup();
    endtask

    task automatic t_either();
        logic [31:0] v;
        wr(ctl(8), 32'h000B_0000);
        set_pin(8, 1'b1);
        tick(1);
        rd(STAT, v); check("R8 rise sets flag", v, 32'h100);
        wr(STAT, 32'h100);
        tick(1);
        rd(STAT, v); check("R8 cleared", v, 32'h0);
        set_pin(8, 1'b0);
        tick(1);
        rd(STAT, v); check("R8 fall sets flag", v, 32'h100);
        cleanup();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(ctl(10), 32'h0009_0000);
        wr(ctl(20), 32'h0009_0000);
        @(negedge clk);
        pin_lvl[10] = 1'b1; pin_lvl[20] = 1'b1;
        tick(1);
        rd(STAT, v); check("R9 two flags", v, 32'h0010_0400);
        wr(STAT, 32'h0000_0400);
        rd(STAT, v); check("R9 partial clear", v, 32'h0010_0000);
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, v); check("R9 clear all", v, 32'h0);
        cleanup();
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(ctl(12), 32'h0009_0000);
        @(negedge clk);
        pin_lvl[12] = 1'b1;
        bus_addr = STAT; bus_wdata = 32'h1000; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
        rd(STAT, v); check("R10 event beats clear", v, 32'h1000);
        cleanup();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(ctl(0), 32'h0009_0000);
        @(negedge clk);
        pin_lvl[0] = 1'b1;
        @(negedge clk);
        rd(STAT, v); check("R11 flag set", v, 32'h1);
        check("R11 irq lags one cycle", {31'h0, irq_o}, 32'h0);
        tick(1);
        check("R11 irq high", {31'h0, irq_o}, 32'h1);
        wr(STAT, 32'h1);
        check("R11 irq still high on clear cycle", {31'h0, irq_o}, 32'h1);
        tick(1);
        check("R11 irq low after clear", {31'h0, irq_o}, 32'h0);
        cleanup();
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(ctl(14), 32'h000B_0000);
        set_pin(14, 1'b1);
        tick(1);
        wr(ctl(14), 32'h0);
        rd(STAT, v); check("R12 old flag kept", v, 32'h4000);
        wr(STAT, 32'h4000);
        set_pin(14, 1'b0);
        tick(1);
        set_pin(14, 1'b1);
        tick(1);
        rd(STAT, v); check("R12 masked pin silent", v, 32'h0);
        cleanup();
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_ctrl_map();
        t_disabled();
        t_level_low();
        t_level_high();
        t_rising();
        t_falling();
        t_either();
        t_w1c();
        t_collide();
        t_irq();
        t_mask();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule